// File: doc/BRIEF.md
# Serial Programming Host Sequencer

This block sits on the programmer side of a four-wire, in-system programming link. It drives a target's reset pin, serial clock and serial data-in line, and samples the target's serial data-out line. A single start strobe runs a complete session. The session puts the target into programming mode, loads one page of 16-bit words from a small local buffer, commits the page and then waits for the target to finish writing. At the end, the target is released back to normal operation.

Every transfer is a 32-bit frame sent most significant bit first. The serial clock idles low and is derived from the system clock. Entry into programming mode is confirmed by an echo byte that comes back during the third byte of the enable frame. If the echo is wrong, the sequencer still completes the frame, pulses the target reset and tries again, up to a parameterised limit. After the page-write frame, the sequencer polls the target's busy bit, or waits a fixed time when polling is turned off by parameter. The three status outputs tell the caller whether the session ended cleanly, failed to synchronise or timed out.

Top module: `spm_host_seq`

## Requirements
- R1: While and after the synchronous reset, `tgt_rst` and `tgt_sck` are low, and `busy`, `done`, `err_sync` and `err_timeout` are all low.
- R2: On `start` in idle, `tgt_rst` is driven high for at least RST_PULSE_CYC cycles with `tgt_sck` held low, and is then driven low. Every retry repeats this pulse.
- R3: At least STARTUP_CYC cycles pass between `tgt_rst` falling and the first rising edge of `tgt_sck`.
- R4: The enable frame is bytes 0xAC, 0x53, 0x00, 0x00. All 32 bits are always sent. The attempt succeeds only if the byte sampled during the third byte equals 0x53.
- R5: After an echo mismatch, the sequencer pulses reset and resends the enable frame. After MAX_SYNC failed attempts, it raises `err_sync` and sends no further frames.
- R6: For each buffer index from 0 upward, the sequencer sends the low-byte load frame {0x40, 0x00, index, word[7:0]} and then the high-byte load frame {0x48, 0x00, index, word[15:8]}. `buf_idx` presents that index while its word is being used.
- R7: Only after the last word's high byte has been loaded, the sequencer sends the page-write frame {0x4C, A[15:8], A[7:0], 0x00}, where A = page_sel × PAGE_WORDS.
- R8: With polling enabled, the sequencer sends poll frames {0xF0, 0x00, 0x00, 0x00}. The busy flag is the last bit sampled in the frame (the LSB of byte four). Polling stops when that bit is 0. After POLL_LIMIT busy answers, the sequencer raises `err_timeout`.
- R9: When a session ends, whether cleanly or with an error, `tgt_rst` goes high, `done` pulses for exactly one cycle and `busy` drops in the same cycle as the pulse.
- R10: Each `tgt_sck` level lasts at least HALF_CYC cycles. `tgt_mosi` changes only while `tgt_sck` is low. `tgt_miso` is sampled as `tgt_sck` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Starts a session when idle |
| page_sel | input | PAGE_W | Page number, captured at start |
| buf_idx | output | log2(PAGE_WORDS) | Word index into the local page buffer |
| buf_word | input | 16 | Buffer word at `buf_idx` |
| tgt_rst | output | 1 | Target reset pin |
| tgt_sck | output | 1 | Serial clock to the target |
| tgt_mosi | output | 1 | Serial data to the target |
| tgt_miso | input | 1 | Serial data from the target |
| busy | output | 1 | Session in progress |
| done | output | 1 | One-cycle end-of-session pulse |
| err_sync | output | 1 | Synchronisation attempts exhausted |
| err_timeout | output | 1 | Target stayed busy for POLL_LIMIT polls |

## Verification
The assertions check the following on every cycle:
- the pin levels forced by reset;
- that the serial clock is low whenever the reset pin is high;
- that the data line is quiet while the clock is high;
- the minimum length of each clock phase;
- that the two error flags are exclusive;
- the pin and busy state at the end pulse.

Some behaviours can only be shown by the bench scenarios, which play a target model against the block:
- the contents and order of the frames;
- retries after a wrong echo, including giving up at the limit;
- the startup gap;
- ending the poll loop on a ready answer or on the timeout.

// File: rtl/spm_pkg.sv
// Shared constants and state type for the serial programming host sequencer.
// Assumes 32-bit frames sent most significant bit first.
package spm_pkg;

    localparam int FRAME_W = 32;

    localparam logic [7:0] OP_ENABLE  = 8'hAC;
    localparam logic [7:0] ECHO_BYTE  = 8'h53;
    localparam logic [7:0] OP_LOAD_LO = 8'h40;
    localparam logic [7:0] OP_LOAD_HI = 8'h48;
    localparam logic [7:0] OP_WRITE   = 8'h4C;
    localparam logic [7:0] OP_POLL    = 8'hF0;

    localparam logic [FRAME_W-1:0] FRAME_ENABLE = {OP_ENABLE, ECHO_BYTE, 8'h00, 8'h00};
    localparam logic [FRAME_W-1:0] FRAME_POLL   = {OP_POLL, 8'h00, 8'h00, 8'h00};

    typedef enum logic [3:0] {
        S_IDLE,
        S_PULSE,
        S_WAIT,
        S_SYNC_W,
        S_LOAD,
        S_LOAD_W,
        S_WRITE_W,
        S_POLL_W,
        S_WWAIT,
        S_END
    } seq_state_t;

endpackage

// File: rtl/spm_interval.sv
// Interval counter: counts cycles while 'run' is high and flags the cycle
// in which the count reaches 'limit'. It restarts from zero after each hit
// and whenever 'run' drops.
// Assumes limit >= 1 whenever run is high.
module spm_interval #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          hit
);

    logic [TW-1:0] cnt;

    assign hit = run && (cnt == limit - TW'(1));

    // Advance the count while running, restart on a hit or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || hit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + TW'(1);
        end
    end

endmodule

// File: rtl/spm_frame_io.sv
// Frame engine: shifts one 32-bit frame out on mosi, MSB first, with an
// idle-low serial clock. Each clock level lasts HALF_CYC system cycles.
// miso is captured on each rising serial clock edge, and mosi advances only
// at the falling edge. The last two received bytes are exposed.
// Assumes start is only pulsed while the engine is idle.
module spm_frame_io
    import spm_pkg::*;
#(
    parameter int HALF_CYC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] tx_frame,
    input  logic               miso,
    output logic               sck,
    output logic               mosi,
    output logic               done,
    output logic [7:0]         rx_echo,
    output logic               rx_last
);

    localparam int PH_W  = $clog2(HALF_CYC) + 1;
    localparam int BIT_W = $clog2(FRAME_W);

    logic               active;
    logic [PH_W-1:0]    ph;
    logic [BIT_W-1:0]   bitn;
    logic [FRAME_W-1:0] tx_sh;
    logic [15:0]        rx_sh;
    logic               phase_end;

    assign phase_end = (ph == PH_W'(HALF_CYC - 1));
    assign mosi      = tx_sh[FRAME_W-1];
    assign rx_echo   = rx_sh[15:8];
    assign rx_last   = rx_sh[0];

    // Phase timing, clock toggling, transmit shift and receive capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            ph     <= '0;
            bitn   <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
            sck    <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    tx_sh  <= tx_frame;
                    ph     <= '0;
                    bitn   <= '0;
                end
            end else if (phase_end) begin
                ph <= '0;
                if (!sck) begin
                    sck   <= 1'b1;
                    rx_sh <= {rx_sh[14:0], miso};
                end else begin
                    sck   <= 1'b0;
                    tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
                    if (bitn == BIT_W'(FRAME_W - 1)) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        bitn <= bitn + BIT_W'(1);
                    end
                end
            end else begin
                ph <= ph + PH_W'(1);
            end
        end
    end

endmodule

// File: rtl/spm_host_seq.sv
// Serial programming host sequencer (top).
// One start strobe runs a full session:
//   - reset pulse, then the startup wait;
//   - enable frame with an echo check, retried on a mismatch;
//   - page-load frames, low byte before high byte for each word;
//   - page-write frame;
//   - busy polling, or a fixed wait when POLL_MODE is 0;
//   - release of the target reset.
// Assumes PAGE_WORDS is a power of two >= 2, PAGE_W + log2(PAGE_WORDS) <= 16,
// and buf_word is valid combinationally for the buf_idx presented.
module spm_host_seq
    import spm_pkg::*;
#(
    parameter int HALF_CYC       = 4,
    parameter int RST_PULSE_CYC  = 8,
    parameter int STARTUP_CYC    = 2000000,
    parameter int MAX_SYNC       = 32,
    parameter int PAGE_WORDS     = 16,
    parameter int PAGE_W         = 8,
    parameter int POLL_MODE      = 1,
    parameter int POLL_LIMIT     = 64,
    parameter int WRITE_WAIT_CYC = 450000,
    localparam int IDX_W         = $clog2(PAGE_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PAGE_W-1:0] page_sel,
    output logic [IDX_W-1:0]  buf_idx,
    input  logic [15:0]       buf_word,
    output logic              tgt_rst,
    output logic              tgt_sck,
    output logic              tgt_mosi,
    input  logic              tgt_miso,
    output logic              busy,
    output logic              done,
    output logic              err_sync,
    output logic              err_timeout
);

    localparam int MAX_A  = (RST_PULSE_CYC > STARTUP_CYC) ? RST_PULSE_CYC : STARTUP_CYC;
    localparam int MAX_T  = (MAX_A > WRITE_WAIT_CYC) ? MAX_A : WRITE_WAIT_CYC;
    localparam int TW     = $clog2(MAX_T + 1);
    localparam int ATT_W  = $clog2(MAX_SYNC + 1);
    localparam int POLL_W = $clog2(POLL_LIMIT + 1);

    seq_state_t         state;
    logic [PAGE_W-1:0]  page_q;
    logic [IDX_W-1:0]   widx;
    logic               hi_half;
    logic [ATT_W-1:0]   attempts;
    logic [POLL_W-1:0]  polls;
    logic               rst_q;
    logic               done_q;
    logic               err_sync_q;
    logic               err_tmo_q;
    logic               fr_start;
    logic [FRAME_W-1:0] fr_tx;
    logic               fr_done;
    logic [7:0]         fr_echo;
    logic               fr_last;
    logic               tmr_run;
    logic               tmr_hit;
    logic [TW-1:0]      tmr_lim;
    logic [15:0]        page_base;

    assign page_base   = 16'(page_q) << IDX_W;
    assign buf_idx     = widx;
    assign tgt_rst     = rst_q;
    assign busy        = (state != S_IDLE);
    assign done        = done_q;
    assign err_sync    = err_sync_q;
    assign err_timeout = err_tmo_q;

    // Pick the interval length for the timed states.
    always_comb begin
        tmr_run = 1'b1;
        case (state)
            S_PULSE: tmr_lim = TW'(RST_PULSE_CYC);
            S_WAIT:  tmr_lim = TW'(STARTUP_CYC);
            S_WWAIT: tmr_lim = TW'(WRITE_WAIT_CYC);
            default: begin
                tmr_lim = TW'(1);
                tmr_run = 1'b0;
            end
        endcase
    end

    spm_interval #(.TW(TW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tmr_run),
        .limit (tmr_lim),
        .hit   (tmr_hit)
    );

    spm_frame_io #(.HALF_CYC(HALF_CYC)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (fr_start),
        .tx_frame (fr_tx),
        .miso     (tgt_miso),
        .sck      (tgt_sck),
        .mosi     (tgt_mosi),
        .done     (fr_done),
        .rx_echo  (fr_echo),
        .rx_last  (fr_last)
    );

    // Session state machine: reset/sync loop, page load, write, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            page_q     <= '0;
            widx       <= '0;
            hi_half    <= 1'b0;
            attempts   <= '0;
            polls      <= '0;
            rst_q      <= 1'b0;
            done_q     <= 1'b0;
            err_sync_q <= 1'b0;
            err_tmo_q  <= 1'b0;
            fr_start   <= 1'b0;
            fr_tx      <= '0;
        end else begin
            fr_start <= 1'b0;
            done_q   <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        state      <= S_PULSE;
                        rst_q      <= 1'b1;
                        attempts   <= '0;
                        err_sync_q <= 1'b0;
                        err_tmo_q  <= 1'b0;
                        page_q     <= page_sel;
                    end
                end
                S_PULSE: begin
                    if (tmr_hit) begin
                        rst_q <= 1'b0;
                        state <= S_WAIT;
                    end
                end
                S_WAIT: begin
                    if (tmr_hit) begin
                        fr_start <= 1'b1;
                        fr_tx    <= FRAME_ENABLE;
                        state    <= S_SYNC_W;
                    end
                end
                S_SYNC_W: begin
                    if (fr_done) begin
                        if (fr_echo == ECHO_BYTE) begin
                            widx  <= '0;
                            state <= S_LOAD;
                        end else if (attempts == ATT_W'(MAX_SYNC - 1)) begin
                            err_sync_q <= 1'b1;
                            state      <= S_END;
                        end else begin
                            attempts <= attempts + ATT_W'(1);
                            rst_q    <= 1'b1;
                            state    <= S_PULSE;
                        end
                    end
                end
                S_LOAD: begin
                    fr_start <= 1'b1;
                    fr_tx    <= {OP_LOAD_LO, 8'h00, 8'(widx), buf_word[7:0]};
                    hi_half  <= 1'b0;
                    state    <= S_LOAD_W;
                end
                S_LOAD_W: begin
                    if (fr_done) begin
                        if (!hi_half) begin
                            hi_half  <= 1'b1;
                            fr_start <= 1'b1;
                            fr_tx    <= {OP_LOAD_HI, 8'h00, 8'(widx), buf_word[15:8]};
                        end else if (widx == IDX_W'(PAGE_WORDS - 1)) begin
                            fr_start <= 1'b1;
                            fr_tx    <= {OP_WRITE, page_base[15:8], page_base[7:0], 8'h00};
                            state    <= S_WRITE_W;
                        end else begin
                            widx  <= widx + IDX_W'(1);
                            state <= S_LOAD;
                        end
                    end
                end
                S_WRITE_W: begin
                    if (fr_done) begin
                        polls <= '0;
                        if (POLL_MODE != 0) begin
                            fr_start <= 1'b1;
                            fr_tx    <= FRAME_POLL;
                            state    <= S_POLL_W;
                        end else begin
                            state <= S_WWAIT;
                        end
                    end
                end
                S_POLL_W: begin
                    if (fr_done) begin
                        if (!fr_last) begin
                            state <= S_END;
                        end else if (polls == POLL_W'(POLL_LIMIT - 1)) begin
                            err_tmo_q <= 1'b1;
                            state     <= S_END;
                        end else begin
                            polls    <= polls + POLL_W'(1);
                            fr_start <= 1'b1;
                            fr_tx    <= FRAME_POLL;
                        end
                    end
                end
                S_WWAIT: begin
                    if (tmr_hit) begin
                        state <= S_END;
                    end
                end
                S_END: begin
                    rst_q  <= 1'b1;
                    done_q <= 1'b1;
                    state  <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spm_host_seq_chk.sv
// Checker for spm_host_seq: pin-level rules that hold on every cycle.
// Attached to the top through the bind statement at the end of this file.
module spm_host_seq_chk #(
    parameter int HALF_CYC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic tgt_rst,
    input logic tgt_sck,
    input logic tgt_mosi,
    input logic busy,
    input logic done,
    input logic err_sync,
    input logic err_timeout
);

    localparam int HW = $clog2(HALF_CYC + 1) + 1;

    logic [HW-1:0] hold;
    logic          sck_q;

    // Count how many cycles the serial clock has held its present level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold  <= HW'(1);
            sck_q <= 1'b0;
        end else begin
            sck_q <= tgt_sck;
            if (tgt_sck != sck_q) begin
                hold <= HW'(1);
            end else if (hold < HW'(HALF_CYC)) begin
                hold <= hold + HW'(1);
            end
        end
    end

    p_pins_low_r1: assert property (@(posedge clk)
        !rst_n |=> (!tgt_rst && !tgt_sck && !busy && !done));

    p_sck_low_in_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_rst |-> !tgt_sck);

    p_mosi_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tgt_mosi) |-> !tgt_sck);

    p_phase_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_sck != sck_q) |-> (hold >= HW'(HALF_CYC)));

    p_single_error_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_sync, err_timeout}));

    p_done_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (tgt_rst && !busy));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind spm_host_seq spm_host_seq_chk #(.HALF_CYC(HALF_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tgt_rst     (tgt_rst),
    .tgt_sck     (tgt_sck),
    .tgt_mosi    (tgt_mosi),
    .busy        (busy),
    .done        (done),
    .err_sync    (err_sync),
    .err_timeout (err_timeout)
);

// File: tb/test_spm_host_seq.sv
// Scoreboard bench for spm_host_seq.
// A session task queues the frames it expects. A behavioural target model
// decodes each frame from the serial pins, answers echo and busy requests,
// and compares every received frame against the head of the queue.
module test_spm_host_seq;

    localparam int HALF    = 2;
    localparam int PULSE   = 5;
    localparam int STARTUP = 300;
    localparam int MAXS    = 4;
    localparam int WORDS   = 4;
    localparam int PGW     = 6;
    localparam int PLIM    = 5;
    localparam int IW      = $clog2(WORDS);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [PGW-1:0] page_sel = '0;
    logic [IW-1:0]  buf_idx;
    logic [15:0]    buf_word;
    logic           tgt_rst, tgt_sck, tgt_mosi;
    logic           tgt_miso = 1'b0;
    logic           busy, done, err_sync, err_timeout;

    logic [15:0] bufmem [WORDS];
    assign buf_word = bufmem[buf_idx];

    int checks = 0;
    int errors = 0;

    logic [31:0] expq[$];
    string       tagq[$];

    int fail_syncs = 0;
    int busy_polls = 0;
    int en_base = 0;
    int enables_total = 0;
    int polls_since = 0;
    int rst_falls = 0;
    int pulse_bad = 0;
    int gap_bad = 0;
    int phase_bad = 0;

    always #5 clk = ~clk;

    spm_host_seq #(
        .HALF_CYC(HALF), .RST_PULSE_CYC(PULSE), .STARTUP_CYC(STARTUP),
        .MAX_SYNC(MAXS), .PAGE_WORDS(WORDS), .PAGE_W(PGW), .POLL_MODE(1),
        .POLL_LIMIT(PLIM), .WRITE_WAIT_CYC(50)
    ) i_spm_host_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .page_sel(page_sel),
        .buf_idx(buf_idx), .buf_word(buf_word), .tgt_rst(tgt_rst),
        .tgt_sck(tgt_sck), .tgt_mosi(tgt_mosi), .tgt_miso(tgt_miso),
        .busy(busy), .done(done), .err_sync(err_sync), .err_timeout(err_timeout)
    );

    task automatic chk(input bit ok, input string what,
                       input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Target model: frame decode, echo and busy answers, scoreboard compare.
    initial begin
        logic        sck_p;
        int          bitn;
        logic [31:0] shin;
        logic [7:0]  outb;
        sck_p = 1'b0;
        bitn  = 0;
        shin  = '0;
        outb  = '0;
        forever begin
            @(tgt_sck or tgt_rst);
            if (tgt_rst) begin
                bitn     = 0;
                tgt_miso = 1'b0;
                outb     = '0;
            end else if (tgt_sck && !sck_p) begin
                shin = {shin[30:0], tgt_mosi};
                bitn++;
                if (bitn == 32) begin
                    bitn = 0;
                    if (expq.size() == 0) begin
                        chk(1'b0, "R4 unexpected frame", shin, 0);
                    end else begin
                        logic [31:0] e;
                        string       t;
                        e = expq.pop_front();
                        t = tagq.pop_front();
                        chk(shin == e, t, shin, e);
                    end
                    if (shin[31:24] == 8'hAC) enables_total++;
                    if (shin[31:24] == 8'h4C) polls_since = 0;
                    if (shin[31:24] == 8'hF0) polls_since++;
                end
            end else if (!tgt_sck && sck_p) begin
                if (bitn == 16)
                    outb = (shin[15:8] == 8'hAC && (enables_total - en_base) >= fail_syncs)
                           ? shin[7:0] : 8'h00;
                else if (bitn == 24)
                    outb = (shin[23:16] == 8'hF0) ? {7'b0, (polls_since < busy_polls)} : 8'h00;
                else if (bitn % 8 == 0)
                    outb = 8'h00;
                tgt_miso = outb[3'(7 - (bitn % 8))];
            end
            sck_p = tgt_sck;
        end
    end

    // Pin timing monitor: reset pulse width, startup gap, clock phase length.
    int   hi_run = 0, gap_run = 0, sck_run = 0;
    bit   gap_arm = 1'b0;
    logic rst_prev = 1'b0, sck_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (tgt_rst) begin
                hi_run++;
            end else if (rst_prev) begin
                rst_falls++;
                if (hi_run < PULSE) pulse_bad++;
                hi_run  = 0;
                gap_arm = 1'b1;
                gap_run = 0;
            end
            if (gap_arm && !tgt_rst) begin
                if (tgt_sck) begin
                    if (gap_run < STARTUP) gap_bad++;
                    gap_arm = 1'b0;
                end else begin
                    gap_run++;
                end
            end
            if (tgt_sck != sck_prev) begin
                if (sck_run < HALF) phase_bad++;
                sck_run = 1;
            end else begin
                sck_run++;
            end
        end
        rst_prev = tgt_rst;
        sck_prev = tgt_sck;
    end

    task automatic push(input logic [31:0] f, input string tag);
        expq.push_back(f);
        tagq.push_back(tag);
    endtask

    // Driver: load the buffer, queue the expected frames, run one session, judge the end state.
    task automatic run_session(input int page, input int fail, input int bp,
                               input bit exp_sync, input bit exp_tmo);
        int n, npoll, fall0, waited;
        bit seen;
        logic [15:0] base;
        for (int i = 0; i < WORDS; i++)
            bufmem[i] = 16'(page * 16'h0123 + i * 16'h1011 + 16'h5AC3);
        fail_syncs = fail;
        busy_polls = bp;
        en_base    = enables_total;
        n = exp_sync ? MAXS : fail + 1;
        for (int i = 0; i < n; i++) push(32'hAC530000, "R4 enable frame");
        if (!exp_sync) begin
            for (int i = 0; i < WORDS; i++) begin
                push({8'h40, 8'h00, 8'(i), bufmem[i][7:0]}, "R6 low load frame");
                push({8'h48, 8'h00, 8'(i), bufmem[i][15:8]}, "R6 high load frame");
            end
            base = 16'(page * WORDS);
            push({8'h4C, base[15:8], base[7:0], 8'h00}, "R7 page write frame");
            npoll = exp_tmo ? PLIM : bp + 1;
            for (int i = 0; i < npoll; i++) push(32'hF0000000, "R8 poll frame");
        end
        fall0 = rst_falls;
        @(negedge clk);
        page_sel = PGW'(page);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 1'b0;
        waited = 0;
        while (!seen && waited < 60000) begin
            @(negedge clk);
            waited++;
            if (done) seen = 1'b1;
        end
        chk(seen, "R9 done pulse seen", seen, 1);
        chk(err_sync == exp_sync, "R5 err_sync at end", err_sync, exp_sync);
        chk(err_timeout == exp_tmo, "R8 err_timeout at end", err_timeout, exp_tmo);
        chk(tgt_rst == 1'b1 && busy == 1'b0, "R9 reset released and idle",
            {tgt_rst, busy}, 2'b10);
        @(negedge clk);
        chk(done == 1'b0, "R9 done lasts one cycle", done, 0);
        chk(expq.size() == 0, "R5 all expected frames seen", expq.size(), 0);
        chk(rst_falls - fall0 == n, "R2 reset pulses per session", rst_falls - fall0, n);
        chk(pulse_bad == 0, "R2 reset pulse width", pulse_bad, 0);
        chk(gap_bad == 0, "R3 startup gap", gap_bad, 0);
        chk(phase_bad == 0, "R10 serial clock phase length", phase_bad, 0);
        expq.delete();
        tagq.delete();
        repeat (10) @(negedge clk);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Stimulus sequence.
    initial begin
        for (int i = 0; i < WORDS; i++) bufmem[i] = '0;
        repeat (4) @(negedge clk);
        chk(tgt_rst == 1'b0 && tgt_sck == 1'b0, "R1 pins low in reset", {tgt_rst, tgt_sck}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(tgt_rst == 1'b0 && tgt_sck == 1'b0, "R1 pins low after reset", {tgt_rst, tgt_sck}, 0);
        chk({busy, done, err_sync, err_timeout} == 4'b0, "R1 status clear after reset",
            {busy, done, err_sync, err_timeout}, 0);
        run_session(3, 2, 3, 1'b0, 1'b0);
        run_session(0, MAXS, 0, 1'b1, 1'b0);
        run_session(63, 0, 100, 1'b0, 1'b1);
        run_session(10, MAXS - 1, 0, 1'b0, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule